// File: doc/BRIEF.md
# Chained Transposable Wordline and Column-Select Addressing

This block produces the row and column-select drive for a row of unit arrays that together hold a weight matrix laid out so that it can be read or written either along a row or along a column. One address decoder serves the first unit array. Every later array takes its selects from its left neighbour through a transition stage steered by a direction bit, so no extra decoders are needed along the chain.

The address has two parts: the upper bits pick one of the wordlines (WL) and the lower bits pick one of the column-select lines (CSL) inside the column multiplexer. For row access every array gets the same (WL, CSL) pair. For column access the first array gets the two's complement of the address, and each transition stage moves the CSL up by one; the WL moves up by one row only when the CSL leaves its highest line. So in column mode array k points at physical location (k − A) modulo the array size, which is the diagonal that holds one logical column after the weights have been rotated on write. The selects are registered once at the output.

Top module: `xpose_wl_chain`

## Requirements
- R1: In row mode (dir = 0), every unit array selects WL = A / N_CSL and CSL = A mod N_CSL, where A is the address; the upper address bits are the WL index and the lowest log2(N_CSL) bits are the CSL index.
- R2: In column mode (dir = 1), unit array 0 selects the location P0 = (S − A) mod S, with S = N_WL·N_CSL, split into WL and CSL the same way as in R1.
- R3: In column mode, the CSL index of array k+1 is that of array k plus one, wrapping from N_CSL−1 to 0.
- R4: In column mode, the WL index of array k+1 equals that of array k unless array k's CSL is the highest line (N_CSL−1), in which case it is one higher.
- R5: A WL step from the top row (N_WL−1) wraps to row 0; together with R2–R4, array k selects location (k − A) mod S.
- R6: While enabled, each array's WL vector and CSL vector each have exactly one bit set.
- R7: While disabled, all WL and CSL outputs are zero.
- R8: Outputs follow the inputs sampled at the previous rising clock edge; during and right after reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Access enable; outputs are zero when low |
| dir | input | 1 | Access direction: 0 row, 1 column |
| addr | input | AW = log2(N_WL·N_CSL) | Row or column address; upper bits WL, lower bits CSL |
| wl_sel | output | N_ARR·N_WL | One-hot WL vector per array, array k at bits [k·N_WL +: N_WL] |
| csl_sel | output | N_ARR·N_CSL | One-hot CSL vector per array, array k at bits [k·N_CSL +: N_CSL] |

## Verification
A fault in a transition stage shows up in that array and every array to its right in the same output cycle, because the selects ripple through the chain with no register between stages; the bench therefore compares every array on every vector, one cycle after the inputs. Column addresses are chosen so the CSL wrap, and thus the WL step, falls on array 0, on a middle array and at the WL top boundary, so a missing carry or a missing wrap changes the diagonal at a known array. A decoder fault in the two's-complement path differs from a stage fault in that array 0 is already wrong.

// File: rtl/xpose_pkg.sv
package xpose_pkg;
   typedef enum logic {
      DIR_ROW = 1'b0,
      DIR_COL = 1'b1
   } xdir_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/xpose_decoder.sv
module xpose_decoder #(
   parameter int N_WL  = 128,
   parameter int N_CSL = 8,
   localparam int AW   = $clog2(N_WL * N_CSL),
   localparam int CW   = $clog2(N_CSL),
   localparam int WW   = AW - CW
) (
   input  logic              en,
   input  logic              dir,
   input  logic [AW-1:0]     addr,
   output logic [N_WL-1:0]   wl,
   output logic [N_CSL-1:0]  csl
);
   import xpose_pkg::*;

   logic [AW-1:0] phys;

   // column access starts from the negated address
   assign phys = (xdir_e'(dir) == DIR_COL) ? (AW'(0) - addr) : addr;

   always_comb begin
      for (int i = 0; i < N_WL; i++)
         wl[i] = en && (phys[AW-1:CW] == WW'(i));
      for (int j = 0; j < N_CSL; j++)
         csl[j] = en && (phys[CW-1:0] == CW'(j));
   end
endmodule

// File: rtl/xpose_step.sv
module xpose_step #(
   parameter int N_WL  = 128,
   parameter int N_CSL = 8
) (
   input  logic              dir,
   input  logic [N_WL-1:0]   wl_in,
   input  logic [N_CSL-1:0]  csl_in,
   output logic [N_WL-1:0]   wl_out,
   output logic [N_CSL-1:0]  csl_out
);
   import xpose_pkg::*;

   logic col;
   logic carry;

   assign col   = (xdir_e'(dir) == DIR_COL);
   assign carry = col && csl_in[N_CSL-1];

   assign csl_out = col   ? {csl_in[N_CSL-2:0], csl_in[N_CSL-1]} : csl_in;
   assign wl_out  = carry ? {wl_in[N_WL-2:0], wl_in[N_WL-1]}     : wl_in;
endmodule

// File: rtl/xpose_wl_chain.sv
module xpose_wl_chain #(
   parameter int N_WL  = 128,
   parameter int N_CSL = 8,
   parameter int N_ARR = 8,
   localparam int AW   = $clog2(N_WL * N_CSL),
   localparam int CW   = $clog2(N_CSL)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic                     dir,
   input  logic [AW-1:0]            addr,
   output logic [N_ARR*N_WL-1:0]    wl_sel,
   output logic [N_ARR*N_CSL-1:0]   csl_sel
);
   import xpose_pkg::*;

   generate
      if (!is_pow2(N_WL) || N_WL < 2) begin : g_bad_wl
         $error("N_WL must be a power of two, at least 2");
      end
      if (!is_pow2(N_CSL) || N_CSL < 2) begin : g_bad_csl
         $error("N_CSL must be a power of two, at least 2");
      end
      if (N_ARR < 1) begin : g_bad_arr
         $error("N_ARR must be at least 1");
      end
   endgenerate

   logic [N_WL-1:0]  wl_c  [N_ARR];
   logic [N_CSL-1:0] csl_c [N_ARR];

   xpose_decoder #(.N_WL(N_WL), .N_CSL(N_CSL)) i_dec (
      .en   (en),
      .dir  (dir),
      .addr (addr),
      .wl   (wl_c[0]),
      .csl  (csl_c[0])
   );

   generate
      for (genvar k = 1; k < N_ARR; k++) begin : g_stage
         xpose_step #(.N_WL(N_WL), .N_CSL(N_CSL)) i_step (
            .dir     (dir),
            .wl_in   (wl_c[k-1]),
            .csl_in  (csl_c[k-1]),
            .wl_out  (wl_c[k]),
            .csl_out (csl_c[k])
         );
      end
   endgenerate

   logic [N_ARR-1:0][N_WL-1:0]  wl_q;
   logic [N_ARR-1:0][N_CSL-1:0] csl_q;
   logic                        en_q;
   logic                        dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wl_q  <= '0;
         csl_q <= '0;
         en_q  <= 1'b0;
         dir_q <= 1'b0;
      end else begin
         for (int k = 0; k < N_ARR; k++) begin
            wl_q[k]  <= wl_c[k];
            csl_q[k] <= csl_c[k];
         end
         en_q  <= en;
         dir_q <= dir;
      end
   end

   assign wl_sel  = wl_q;
   assign csl_sel = csl_q;

   // R8
   row_csl_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !dir) |=> csl_q[0][$past(addr[CW-1:0])]);

   generate
      for (genvar k = 0; k < N_ARR; k++) begin : g_chk
         // R6
         onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            en_q |-> ($countones(wl_q[k]) == 1 && $countones(csl_q[k]) == 1));
         // R7
         idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q |-> (wl_q[k] == '0 && csl_q[k] == '0));
         if (k > 0) begin : g_link
            // R1
            row_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (en_q && !dir_q) |-> (wl_q[k] == wl_q[0] && csl_q[k] == csl_q[0]));
            // R4
            wl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (en_q && dir_q && !csl_q[k-1][N_CSL-1]) |-> wl_q[k] == wl_q[k-1]);
            // R3
            csl_zero_after_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (en_q && dir_q && csl_q[k-1][N_CSL-1]) |-> csl_q[k][0]);
         end
      end
   endgenerate
endmodule

// File: tb/test_xpose_wl_chain.sv
module test_xpose_wl_chain;
   localparam int N_WL  = 128;
   localparam int N_CSL = 8;
   localparam int N_ARR = 8;
   localparam int S     = N_WL * N_CSL;
   localparam int AW    = $clog2(S);

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   en = 1'b0;
   logic                   dir = 1'b0;
   logic [AW-1:0]          addr = '0;
   logic [N_ARR*N_WL-1:0]  wl_sel;
   logic [N_ARR*N_CSL-1:0] csl_sel;

   typedef struct {
      bit en;
      bit dir;
      int addr;
   } item_t;

   item_t q[$];
   int    n_vec = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;

   always #5 clk = ~clk;

   xpose_wl_chain #(.N_WL(N_WL), .N_CSL(N_CSL), .N_ARR(N_ARR)) i_xpose_wl_chain (
      .clk(clk), .rst_n(rst_n), .en(en), .dir(dir), .addr(addr),
      .wl_sel(wl_sel), .csl_sel(csl_sel)
   );

   task automatic drive(input bit e, input bit d, input int a);
      item_t it;
      @(negedge clk);
      en = e; dir = d; addr = AW'(a);
      it.en = e; it.dir = d; it.addr = a;
      q.push_back(it);
   endtask

   // monitor: outputs settle one rising edge after the driving negedge
   initial begin
      forever begin
         @(posedge clk); #2;
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            for (int k = 0; k < N_ARR; k++) begin
               logic [N_WL-1:0]  ew, aw;
               logic [N_CSL-1:0] ec, ac;
               int p;
               string tag;
               ew = '0; ec = '0;
               if (!it.en) begin
                  tag = "R7";
               end else if (!it.dir) begin
                  tag = "R1 R6";
                  p = it.addr;
                  ew[p / N_CSL] = 1'b1; ec[p % N_CSL] = 1'b1;
               end else begin
                  tag = "R2 R3 R4 R5 R6";
                  p = (S - it.addr + k) % S;
                  ew[p / N_CSL] = 1'b1; ec[p % N_CSL] = 1'b1;
               end
               aw = wl_sel[k*N_WL +: N_WL];
               ac = csl_sel[k*N_CSL +: N_CSL];
               n_vec++;
               if (aw !== ew || ac !== ec) begin
                  n_bad++;
                  $display("FAIL %s en=%0b dir=%0b addr=%0d array %0d: wl=%h csl=%b expected wl=%h csl=%b",
                           tag, it.en, it.dir, it.addr, k, aw, ac, ew, ec);
               end
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8 reset state
      n_vec++;
      if (wl_sel !== '0 || csl_sel !== '0) begin
         n_bad++;
         $display("FAIL R8 reset: wl=%h csl=%h expected all zero", wl_sel, csl_sel);
      end
      rst_n = 1'b1;
      // R1 row mode
      drive(1, 0, 0);
      drive(1, 0, 5);
      drive(1, 0, S - 1);
      drive(1, 0, 8 * 77 + 3);
      // R7 disabled, with live address
      drive(0, 1, 9);
      drive(0, 0, 123);
      // R2 R3 R4 column mode: addr 0 gives locations 0..7, no carry
      drive(1, 1, 0);
      // R5 addr 1: array 0 at top row top CSL, wraps to row 0
      drive(1, 1, 1);
      // R4 carry on a middle array
      drive(1, 1, 3);
      drive(1, 1, 8 * 5 + 4);
      drive(1, 1, S - 8);
      drive(1, 1, 13);
      for (int i = 0; i < 200; i++)
         drive(1'b1, i[0] ^ i[3], (i * 389 + 71) % S);
      drive(0, 0, 0);
      drive(0, 0, 0);
      repeat (3) @(negedge clk);
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule